// File: doc/BRIEF.md
# Message Header Validator and Dispatcher

This block handles the "process message" step of a command engine. Software first fills a small byte buffer through a plain write port. It then raises a one-cycle go request together with a buffer-present flag and a configured buffer size. The block reads a fixed 24-byte header from the start of the buffer: a 128-bit identifier followed by a 64-bit payload length. It checks that the header and the payload fit in the buffer, and it zero-fills the unused buffer space after the message. It then compares the identifier against a small table of known values.

Three identifiers act as boot-phase events. Each one sets its own sticky flag. Two identifiers route the message to a variable-handler port or to a policy-handler port, through a one-cycle select strobe. Any other identifier is answered with not-supported. The message stays in place in the buffer, so software can read the header and payload back through the same port after dispatch.

The control is one state machine with four states. IDLE waits for go, and go moves it to CHECK. CHECK validates the captured size and the header length. From CHECK, a rejection returns to IDLE with a done pulse, and an acceptance moves to CLEAR. CLEAR zero-fills the tail of the buffer and always moves to MATCH. MATCH compares the identifier, posts the result and returns to IDLE. A soft reset sends any state straight back to IDLE.

Top module: `msg_hdr_dispatch`

## Requirements
- R1: After hard reset (`rst_n` low), `done`, `sel_var`, `sel_pol`, `policy_locked` and all `evt_flags` bits are 0, `status` is 0 (success) and `busy` is 0.
- R2: If `buf_valid` is 0 at go, or the effective size is below 24 bytes, the command ends with `status` = 1 (bad buffer size). In that case no select strobe is raised, no flag changes and the buffer is left unchanged.
- R3: The effective size is `buf_size` limited to DEPTH. The length check adds 24 to the 64-bit length field (bytes 16 to 23, little-endian) using 65-bit arithmetic. A carry out of bit 63, or a sum larger than the effective size, gives `status` = 1.
- R4: On acceptance, every byte from address 24+length up to, but not including, the effective size reads 0 afterwards. All other bytes keep their values.
- R5: The identifier (bytes 0 to 15, little-endian) equal to table entry 2, 3 or 4 sets `evt_flags` bit 0, 1 or 2 respectively, with `status` = 0.
- R6: The identifier equal to table entry 0 pulses `sel_var`, and table entry 1 pulses `sel_pol`. Either strobe comes in the same cycle as `done`, with `status` = 0.
- R7: An identifier matching no table entry gives `status` = 2 (not supported), with no strobe and no flag change.
- R8: `done` is a one-cycle pulse. Counting the clock edge that samples go as edge 1, a rejected command signals at edge 2 and an accepted one at edge 4.
- R9: `evt_flags` bits and `policy_locked` (set by `pol_lock_set`) are cleared only by `rst_n`. A `soft_rst` pulse aborts any command and sets `status` to 0, but leaves these flags set.
- R10: Software writes arriving while `busy` is 1 are ignored. After dispatch, the header and payload bytes read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset, aborts the command and keeps the flags |
| cmd_go | input | 1 | Start processing the staged buffer |
| buf_valid | input | 1 | A buffer is present |
| buf_size | input | SIZE_W | Configured buffer size in bytes |
| sw_we | input | 1 | Software byte write enable |
| sw_addr | input | AW | Software byte address (read and write) |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Buffer byte at `sw_addr` |
| pol_lock_set | input | 1 | Sets the sticky policy-lock flag |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Command finished (one-cycle pulse) |
| status | output | 2 | 0 success, 1 bad buffer size, 2 not supported |
| evt_flags | output | 3 | Sticky boot-phase event flags |
| policy_locked | output | 1 | Sticky policy-lock flag |
| sel_var | output | 1 | Route strobe to the variable handler |
| sel_pol | output | 1 | Route strobe to the policy handler |

## Verification
Zero-fill and a software write can fall in the same cycle. The write port stays open to software, and the CLEAR state rewrites buffer bytes in parallel. The bench provokes the overlap by driving a write to a payload byte exactly in the cycle the machine spends in CLEAR. It then judges the outcome by reading that byte back: it must still hold its staged value, while the tail region reads zero. Around this case, a sweep over lengths and sizes compares every buffer byte with the arithmetic expectation.

// File: rtl/mhv_pkg.sv
package mhv_pkg;

    localparam int HDR_BYTES = 24;
    localparam int ID_BITS   = 128;
    localparam int LEN_BITS  = 64;
    localparam int N_IDS     = 5;
    localparam int N_EVT     = 3;
    localparam int IDX_VAR   = 0;
    localparam int IDX_POL   = 1;
    localparam int IDX_EVT0  = 2;

    typedef enum logic [1:0] {
        STS_OK       = 2'd0,
        STS_BAD_SIZE = 2'd1,
        STS_UNSUPP   = 2'd2
    } status_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_CLEAR = 2'd2,
        S_MATCH = 2'd3
    } fsm_e;

    function automatic logic [ID_BITS-1:0] id_entry(input int idx);
        logic [ID_BITS-1:0] v;
        unique case (idx)
            0:       v = 128'h6c3e_19a0_5d42_8b17_e2f4_0c99_31ad_7b58;
            1:       v = 128'h0a1b_2c3d_4e5f_6071_8293_a4b5_c6d7_e8f9;
            2:       v = 128'hd00d_feed_1357_2468_9bdf_ace0_1122_3344;
            3:       v = 128'h5a5a_0f0f_c3c3_9696_7e7e_2b2b_e1e1_4d4d;
            default: v = 128'h8e21_f0b3_47c6_d5a9_1302_6b8f_fa5e_c917;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mhv_len_check.sv
module mhv_len_check
    import mhv_pkg::*;
#(
    parameter int SIZE_W = 16
) (
    input  logic                present,
    input  logic [SIZE_W-1:0]   eff_size,
    input  logic [LEN_BITS-1:0] pay_len,
    output logic                reject,
    output logic [SIZE_W-1:0]   msg_end
);

    logic [LEN_BITS:0] total;
    logic              carry;
    logic              too_small;
    logic              too_long;

    always_comb begin
        total     = {1'b0, pay_len} + (LEN_BITS+1)'(HDR_BYTES);
        carry     = total[LEN_BITS];
        too_small = eff_size < SIZE_W'(HDR_BYTES);
        too_long  = total[LEN_BITS-1:0] > LEN_BITS'(eff_size);
        reject    = !present || too_small || carry || too_long;
        msg_end   = total[SIZE_W-1:0];
    end

endmodule

// File: rtl/mhv_id_match.sv
module mhv_id_match
    import mhv_pkg::*;
(
    input  logic [ID_BITS-1:0] ident,
    output logic [N_IDS-1:0]   hit,
    output logic               known
);

    for (genvar g = 0; g < N_IDS; g++) begin : g_cmp
        assign hit[g] = (ident == id_entry(g));
    end

    assign known = |hit;

endmodule

// File: rtl/mhv_buf_mem.sv
module mhv_buf_mem
    import mhv_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int SIZE_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    input  logic                   clr_en,
    input  logic [SIZE_W-1:0]      clr_lo,
    input  logic [SIZE_W-1:0]      clr_hi,
    output logic [HDR_BYTES*8-1:0] hdr
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (clr_en && (SIZE_W'(i) >= clr_lo) && (SIZE_W'(i) < clr_hi)) begin
                    mem_q[i] <= 8'h00;
                end else if (wr_en && (addr == AW'(i))) begin
                    mem_q[i] <= wdata;
                end
            end
        end
    end

    assign rdata = mem_q[addr];

    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
        assign hdr[8*g +: 8] = mem_q[g];
    end

    // R4: first byte of the cleared range reads zero afterwards
    a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && (clr_lo < clr_hi) && (clr_lo < SIZE_W'(DEPTH)))
        |=> (mem_q[$past(clr_lo[AW-1:0])] == 8'h00));

endmodule

// File: rtl/msg_hdr_dispatch.sv
module msg_hdr_dispatch
    import mhv_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int SIZE_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cmd_go,
    input  logic              buf_valid,
    input  logic [SIZE_W-1:0] buf_size,
    input  logic              sw_we,
    input  logic [AW-1:0]     sw_addr,
    input  logic [7:0]        sw_wdata,
    output logic [7:0]        sw_rdata,
    input  logic              pol_lock_set,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [N_EVT-1:0]  evt_flags,
    output logic              policy_locked,
    output logic              sel_var,
    output logic              sel_pol
);

    fsm_e                   state_q;
    fsm_e                   state_d;
    logic                   present_q;
    logic [SIZE_W-1:0]      size_q;
    logic [SIZE_W-1:0]      eff_size;
    logic [HDR_BYTES*8-1:0] hdr;
    logic                   reject;
    logic [SIZE_W-1:0]      msg_end;
    logic [N_IDS-1:0]       hit;
    logic                   known;
    logic                   wr_en;
    logic                   clr_en;

    // captured request and clamped size
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            present_q <= 1'b0;
            size_q    <= '0;
        end else if (state_q == S_IDLE && cmd_go) begin
            present_q <= buf_valid;
            size_q    <= (buf_size > SIZE_W'(DEPTH)) ? SIZE_W'(DEPTH) : buf_size;
        end
    end

    assign eff_size = size_q;
    assign busy     = (state_q != S_IDLE);
    assign wr_en    = sw_we && !busy;
    assign clr_en   = (state_q == S_CLEAR);

    mhv_buf_mem #(.DEPTH(DEPTH), .SIZE_W(SIZE_W)) buf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (sw_addr),
        .wdata  (sw_wdata),
        .rdata  (sw_rdata),
        .clr_en (clr_en),
        .clr_lo (msg_end),
        .clr_hi (eff_size),
        .hdr    (hdr)
    );

    mhv_len_check #(.SIZE_W(SIZE_W)) len_i (
        .present  (present_q),
        .eff_size (eff_size),
        .pay_len  (hdr[ID_BITS +: LEN_BITS]),
        .reject   (reject),
        .msg_end  (msg_end)
    );

    mhv_id_match id_i (
        .ident (hdr[ID_BITS-1:0]),
        .hit   (hit),
        .known (known)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else if (soft_rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cmd_go) state_d = S_CHECK;
            S_CHECK: state_d = reject ? S_IDLE : S_CLEAR;
            S_CLEAR: state_d = S_MATCH;
            S_MATCH: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done          <= 1'b0;
            status        <= STS_OK;
            evt_flags     <= '0;
            policy_locked <= 1'b0;
            sel_var       <= 1'b0;
            sel_pol       <= 1'b0;
        end else begin
            done    <= 1'b0;
            sel_var <= 1'b0;
            sel_pol <= 1'b0;
            if (pol_lock_set) begin
                policy_locked <= 1'b1;
            end
            if (soft_rst) begin
                status <= STS_OK;
            end else begin
                unique case (state_q)
                    S_CHECK: begin
                        if (reject) begin
                            done   <= 1'b1;
                            status <= STS_BAD_SIZE;
                        end
                    end
                    S_MATCH: begin
                        done      <= 1'b1;
                        status    <= known ? STS_OK : STS_UNSUPP;
                        sel_var   <= hit[IDX_VAR];
                        sel_pol   <= hit[IDX_POL];
                        evt_flags <= evt_flags | hit[IDX_EVT0 +: N_EVT];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: at most one handler strobe per completion
    a_r6_one_route: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0({sel_var, sel_pol}));

    // R6: a strobe only accompanies a successful completion
    a_r6_route_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_var || sel_pol) |-> (done && status == STS_OK));

    // R2: a rejected buffer never reaches a handler
    a_r2_bad_no_route: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == STS_BAD_SIZE) |-> (!sel_var && !sel_pol));

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: event flags never fall outside hard reset
    a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt_flags) & ~evt_flags) == '0));

    // R9: policy lock never falls outside hard reset
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(policy_locked));

    // R5: a new event flag appears only with a completion
    a_r5_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_flags & ~$past(evt_flags)) != '0) |-> (done && status == STS_OK));

    // R10: the machine is idle whenever a completion is posted
    a_r10_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/msg_hdr_dispatch_tb_top.sv
`timescale 1ns/1ps
module msg_hdr_dispatch_tb_top;
    import mhv_pkg::*;

    localparam int DEPTH  = 64;
    localparam int SIZE_W = 16;
    localparam int AW     = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              soft_rst = 1'b0;
    logic              cmd_go = 1'b0;
    logic              buf_valid = 1'b0;
    logic [SIZE_W-1:0] buf_size = '0;
    logic              sw_we = 1'b0;
    logic [AW-1:0]     sw_addr = '0;
    logic [7:0]        sw_wdata = '0;
    logic [7:0]        sw_rdata;
    logic              pol_lock_set = 1'b0;
    logic              busy;
    logic              done;
    logic [1:0]        status;
    logic [N_EVT-1:0]  evt_flags;
    logic              policy_locked;
    logic              sel_var;
    logic              sel_pol;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] model [DEPTH];
    int         lat;
    logic [1:0] r_sts;
    logic [2:0] r_flg;
    logic       r_sv;
    logic       r_sp;

    always #2.5 clk = ~clk;

    msg_hdr_dispatch #(.DEPTH(DEPTH), .SIZE_W(SIZE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_go(cmd_go),
        .buf_valid(buf_valid), .buf_size(buf_size), .sw_we(sw_we),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .pol_lock_set(pol_lock_set), .busy(busy), .done(done),
        .status(status), .evt_flags(evt_flags), .policy_locked(policy_locked),
        .sel_var(sel_var), .sel_pol(sel_pol)
    );

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_buf(input logic [127:0] id, input logic [63:0] len);
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] b;
            if (i < 16)      b = id[8*i +: 8];
            else if (i < 24) b = len[8*(i-16) +: 8];
            else             b = 8'h80 | 8'(i);
            model[i] = b;
            @(negedge clk);
            sw_we = 1'b1; sw_addr = AW'(i); sw_wdata = b;
        end
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    // inject >= 0: drive a write to that byte during the clear cycle
    task automatic run_cmd(input logic valid, input logic [SIZE_W-1:0] sz, input int inject);
        @(negedge clk);
        buf_valid = valid; buf_size = sz; cmd_go = 1'b1;
        lat = 0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk);
            @(negedge clk);
            cmd_go = 1'b0; sw_we = 1'b0;
            lat++;
            if (done) break;
            if (inject >= 0 && lat == 2) begin
                sw_we = 1'b1; sw_addr = AW'(inject); sw_wdata = 8'h77;
            end
        end
        sw_we = 1'b0;
        r_sts = status; r_flg = evt_flags; r_sv = sel_var; r_sp = sel_pol;
    endtask

    // compare every byte with the staged pattern, zero in [lo, hi)
    task automatic verify_bytes(input int lo, input int hi, input string tag);
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] e;
            e = (i >= lo && i < hi) ? 8'h00 : model[i];
            @(negedge clk);
            sw_addr = AW'(i);
            #1;
            if (sw_rdata !== e) begin
                if (bad == 0) begin first_act = int'(sw_rdata); first_exp = int'(e); end
                bad++;
            end
        end
        chk(bad == 0, tag, first_act, first_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int sizes [5] = '{24, 30, 41, 64, 200};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({done, sel_var, sel_pol, policy_locked, busy} == 5'b0, "R1 ctrl outs", {done, sel_var, sel_pol, policy_locked, busy}, 0);
        chk(evt_flags == 3'b0, "R1 flags", evt_flags, 0);
        chk(status == 2'd0, "R1 status", status, 0);

        // R2 absent buffer, and size below the header
        load_buf(id_entry(IDX_VAR), 64'd0);
        run_cmd(1'b0, 16'd64, -1);
        chk(r_sts == 2'd1, "R2 absent status", r_sts, 1);
        chk(!r_sv && !r_sp && r_flg == 0, "R2 absent no route", {r_sv, r_sp, r_flg}, 0);
        chk(lat == 2, "R8 reject latency", lat, 2);
        run_cmd(1'b1, 16'd10, -1);
        chk(r_sts == 2'd1, "R2 small status", r_sts, 1);
        verify_bytes(0, 0, "R2 buffer untouched");

        // R3/R4/R6/R8 sweep over sizes and lengths
        foreach (sizes[s]) begin
            for (int len = 0; len <= 44; len++) begin
                int eff;
                int tot;
                logic exp_bad;
                eff = (sizes[s] > DEPTH) ? DEPTH : sizes[s];
                tot = 24 + len;
                exp_bad = tot > eff;
                load_buf(id_entry(IDX_VAR), 64'(len));
                run_cmd(1'b1, SIZE_W'(sizes[s]), -1);
                chk(r_sts == (exp_bad ? 2'd1 : 2'd0), "R3 length status", r_sts, exp_bad ? 1 : 0);
                chk(lat == (exp_bad ? 2 : 4), "R8 latency", lat, exp_bad ? 2 : 4);
                chk(r_sv == !exp_bad && !r_sp, "R6 var strobe", {r_sv, r_sp}, exp_bad ? 0 : 2);
                if (exp_bad) verify_bytes(0, 0, "R4 untouched on reject");
                else         verify_bytes(tot, eff, "R4 zero fill");
            end
        end

        // R3 overflow of the 64-bit sum
        load_buf(id_entry(IDX_VAR), 64'hFFFF_FFFF_FFFF_FFE8);
        run_cmd(1'b1, 16'd64, -1);
        chk(r_sts == 2'd1, "R3 carry out", r_sts, 1);
        load_buf(id_entry(IDX_VAR), 64'hFFFF_FFFF_FFFF_FFFF);
        run_cmd(1'b1, 16'd64, -1);
        chk(r_sts == 2'd1, "R3 wrap small", r_sts, 1);
        load_buf(id_entry(IDX_VAR), 64'hFFFF_FFFF_FFFF_FFE7);
        run_cmd(1'b1, 16'd64, -1);
        chk(r_sts == 2'd1, "R3 no carry too long", r_sts, 1);

        // R5 events, one at a time
        for (int k = 0; k < 3; k++) begin
            load_buf(id_entry(IDX_EVT0 + k), 64'd2);
            run_cmd(1'b1, 16'd64, -1);
            chk(r_sts == 2'd0, "R5 event status", r_sts, 0);
            chk(r_flg == 3'((1 << (k + 1)) - 1), "R5 event flags", r_flg, (1 << (k + 1)) - 1);
            chk(!r_sv && !r_sp, "R5 event no route", {r_sv, r_sp}, 0);
        end

        // R6 policy route
        load_buf(id_entry(IDX_POL), 64'd8);
        run_cmd(1'b1, 16'd64, -1);
        chk(r_sp && !r_sv && r_sts == 2'd0, "R6 policy strobe", {r_sv, r_sp, r_sts}, 4);

        // R7 unknown identifiers
        load_buf(128'h0, 64'd0);
        run_cmd(1'b1, 16'd64, -1);
        chk(r_sts == 2'd2, "R7 zero id", r_sts, 2);
        load_buf(id_entry(IDX_VAR) ^ 128'h1, 64'd0);
        run_cmd(1'b1, 16'd64, -1);
        chk(r_sts == 2'd2 && !r_sv && !r_sp && r_flg == 3'b111, "R7 near id", {r_sts, r_sv, r_sp}, 8);

        // R10 write during the clear cycle is ignored; payload kept
        load_buf(id_entry(IDX_VAR), 64'd10);
        run_cmd(1'b1, 16'd64, 30);
        chk(r_sts == 2'd0, "R10 collision status", r_sts, 0);
        verify_bytes(34, 64, "R10 busy write ignored");

        // R9 policy lock and soft reset
        @(negedge clk); pol_lock_set = 1'b1;
        @(negedge clk); pol_lock_set = 1'b0;
        chk(policy_locked == 1'b1, "R9 lock set", policy_locked, 1);
        load_buf(128'h0, 64'd0);
        run_cmd(1'b1, 16'd64, -1);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk(status == 2'd0, "R9 soft status", status, 0);
        chk(evt_flags == 3'b111 && policy_locked, "R9 soft keeps flags", {evt_flags, policy_locked}, 15);
        // soft reset in the middle of a command aborts it
        load_buf(id_entry(IDX_VAR), 64'd0);
        @(negedge clk); buf_valid = 1'b1; buf_size = 16'd64; cmd_go = 1'b1;
        @(negedge clk); cmd_go = 1'b0; soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk(!busy && !done, "R9 soft abort", {busy, done}, 0);
        repeat (4) begin
            @(negedge clk);
            chk(!done, "R9 no done after abort", done, 0);
        end

        // R9 hard reset clears sticky state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(evt_flags == 3'b0 && !policy_locked, "R9 hard clears", {evt_flags, policy_locked}, 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule